// File: doc/BRIEF.md
# Character LCD write-cycle generator

This block carries out a single write transaction on an 8-bit parallel character LCD bus. A request brings a register-select bit, one byte and a two-bit completion-delay class. The block latches all three and places the select bit and the byte on the bus in the same cycle. After a setup interval it raises the enable strobe, holds it high for a minimum width and then drops it. It then waits for the execution time the display controller needs for that kind of instruction, and finally signals completion with a one-cycle pulse.

The display's busy flag is never read. The completion wait is open-loop: the caller picks it through the delay class, and the block times it by counting clock cycles. The read/write line stays low at all times because the block only writes. A single shared counter times every phase. It is cleared whenever the sequencer changes phase. The default cycle counts assume a 50 MHz clock, and every count is a parameter.

Top module: `lcdw_gen`

## Requirements
- R1: Out of reset, enable, done and busy are 0, and the register-select and data bus outputs are 0. The block stays idle until a start request is accepted.
- R2: The read/write output is 0 in every cycle.
- R3: On the clock edge that accepts a start, the register-select and data bus outputs take the requested values. They keep those values until the next accepted start, including the idle time after done.
- R4: Enable rises exactly SETUP_CYC clock edges after the accepting edge (default 4, which is 80 ns at 50 MHz).
- R5: Enable stays high for exactly EHI_CYC cycles (default 16, which is 320 ns at 50 MHz) and then falls.
- R6: After enable falls, the block waits a number of cycles chosen by the delay class before done: class 0 = WAIT0_CYC (default 2,000), class 1 = WAIT1_CYC (5,000), class 2 = WAIT2_CYC (82,000), class 3 = WAIT3_CYC (205,000).
- R7: Done is high for exactly one cycle, SETUP_CYC+EHI_CYC+wait cycles after the accepting edge.
- R8: Busy is high from the cycle after the accepting edge until the done cycle. It is low in the done cycle and while idle.
- R9: A start request seen while busy is ignored. The bus outputs, the enable timing and the done timing are not changed by it.
- R10: A start held high during the done cycle is accepted on the next edge, so transactions can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a write transaction (sampled only while idle) |
| rs_i | input | 1 | Register-select value for the request |
| data_i | input | 8 | Byte to write |
| dly_cls_i | input | 2 | Completion-delay class for the request |
| lcd_rs_o | output | 1 | Register-select line to the display |
| lcd_rw_o | output | 1 | Read/write line, always 0 |
| lcd_e_o | output | 1 | Enable strobe |
| lcd_db_o | output | 8 | Data bus to the display |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start request that arrives while a transaction is running, especially in the first cycle after acceptance and during the enable-high window. At those points the byte and the select bit are being held for the display, and a wrong re-latch would corrupt them. The bench scales down the cycle parameters so that every delay class can be run in full. It then injects a second request with different data at a randomly chosen busy cycle, plus directed cases at the first busy cycle and inside the strobe. It also holds start high through the done cycle to cover back-to-back acceptance.

// File: rtl/lcdw_pkg.sv
// Shared types and helpers for the LCD write-cycle generator.
// Assumes: all cycle counts are positive integers.
package lcdw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_EHI   = 2'd2,
        ST_WAIT  = 2'd3
    } lcdw_state_e;

    // Larger of two integers, used to size the shared counter.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcdw_timer.sv
// Shared phase counter: counts up every cycle and is cleared on request.
// Reports a hit when the count equals the terminal count minus one.
// Assumes: term_i is at least 1 whenever hit_o is used.
module lcdw_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count up, clear on reset or clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    // Terminal compare for the current phase.
    always_comb begin
        hit_o = (cnt_q == (term_i - 1'b1));
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/lcdw_dly_sel.sv
// Maps the latched delay class to a completion-wait length in cycles.
// Assumes: every wait parameter fits in CNT_W bits.
module lcdw_dly_sel #(
    parameter int CNT_W     = 18,
    parameter int WAIT0_CYC = 2000,
    parameter int WAIT1_CYC = 5000,
    parameter int WAIT2_CYC = 82000,
    parameter int WAIT3_CYC = 205000
) (
    input  logic [1:0]       cls_i,
    output logic [CNT_W-1:0] cyc_o
);

    localparam logic [CNT_W-1:0] W0 = CNT_W'(WAIT0_CYC);
    localparam logic [CNT_W-1:0] W1 = CNT_W'(WAIT1_CYC);
    localparam logic [CNT_W-1:0] W2 = CNT_W'(WAIT2_CYC);
    localparam logic [CNT_W-1:0] W3 = CNT_W'(WAIT3_CYC);

    // Class-to-length lookup.
    always_comb begin
        unique case (cls_i)
            2'd0:    cyc_o = W0;
            2'd1:    cyc_o = W1;
            2'd2:    cyc_o = W2;
            default: cyc_o = W3;
        endcase
    end

endmodule

// File: rtl/lcdw_seq.sv
// Write-cycle sequencer: latches a request, then steps through setup,
// enable-high and completion-wait phases timed by the shared counter.
// Assumes: the counter is cleared on every phase change and while idle.
module lcdw_seq
    import lcdw_pkg::*;
#(
    parameter int CNT_W     = 18,
    parameter int SETUP_CYC = 4,
    parameter int EHI_CYC   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rs_i,
    input  logic [7:0]       data_i,
    input  logic [1:0]       cls_i,
    input  logic [CNT_W-1:0] wait_cyc_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             hit_i,
    output logic [1:0]       cls_o,
    output logic [CNT_W-1:0] term_o,
    output logic             clr_o,
    output logic             rs_o,
    output logic [7:0]       db_o,
    output logic             e_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] SETUP_T = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] EHI_T   = CNT_W'(EHI_CYC);

    lcdw_state_e      state_q, state_d;
    logic             rs_q, e_q, done_q;
    logic [7:0]       db_q;
    logic [1:0]       cls_q;

    // Next-phase decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SETUP;
            ST_SETUP: if (hit_i)   state_d = ST_EHI;
            ST_EHI:   if (hit_i)   state_d = ST_WAIT;
            default:  if (hit_i)   state_d = ST_IDLE;
        endcase
    end

    // Terminal count and counter clear for the current phase.
    always_comb begin
        unique case (state_q)
            ST_SETUP: term_o = SETUP_T;
            ST_EHI:   term_o = EHI_T;
            ST_WAIT:  term_o = wait_cyc_i;
            default:  term_o = CNT_W'(1);
        endcase
        clr_o = (state_q == ST_IDLE) || (state_d != state_q);
    end

    // Phase register, request latch, strobe and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rs_q    <= 1'b0;
            db_q    <= '0;
            cls_q   <= '0;
            e_q     <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                rs_q  <= rs_i;
                db_q  <= data_i;
                cls_q <= cls_i;
            end
            e_q    <= (state_d == ST_EHI);
            done_q <= (state_q == ST_WAIT) && hit_i;
        end
    end

    assign rs_o   = rs_q;
    assign db_o   = db_q;
    assign cls_o  = cls_q;
    assign e_o    = e_q;
    assign done_o = done_q;
    assign busy_o = (state_q != ST_IDLE);

    // Enable rises only after a full setup phase.
    assert_setup_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_q) |-> ($past(state_q) == ST_SETUP && $past(cnt_i) == SETUP_T - 1'b1));

    // Enable falls only after a full high phase.
    assert_ehi_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_q) |-> ($past(state_q) == ST_EHI && $past(cnt_i) == EHI_T - 1'b1));

    // Completion wait never runs past its selected length.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (cnt_i < wait_cyc_i));

    // Done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/lcdw_gen.sv
// Top of the LCD write-cycle generator: one 8-bit write per request,
// with setup, enable width and a class-selected completion wait.
// Assumes: defaults are cycle counts for a 50 MHz clock; R/W is never high.
module lcdw_gen #(
    parameter int SETUP_CYC = 4,
    parameter int EHI_CYC   = 16,
    parameter int WAIT0_CYC = 2000,
    parameter int WAIT1_CYC = 5000,
    parameter int WAIT2_CYC = 82000,
    parameter int WAIT3_CYC = 205000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rs_i,
    input  logic [7:0] data_i,
    input  logic [1:0] dly_cls_i,
    output logic       lcd_rs_o,
    output logic       lcd_rw_o,
    output logic       lcd_e_o,
    output logic [7:0] lcd_db_o,
    output logic       busy_o,
    output logic       done_o
);
    import lcdw_pkg::*;

    localparam int MAX_CYC = imax(imax(imax(SETUP_CYC, EHI_CYC), imax(WAIT0_CYC, WAIT1_CYC)),
                                  imax(WAIT2_CYC, WAIT3_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [1:0]       cls;
    logic [CNT_W-1:0] wait_cyc, term, cnt;
    logic             clr, hit;

    lcdw_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .term_i (term),
        .cnt_o  (cnt),
        .hit_o  (hit)
    );

    lcdw_dly_sel #(
        .CNT_W     (CNT_W),
        .WAIT0_CYC (WAIT0_CYC),
        .WAIT1_CYC (WAIT1_CYC),
        .WAIT2_CYC (WAIT2_CYC),
        .WAIT3_CYC (WAIT3_CYC)
    ) u_dly (
        .cls_i (cls),
        .cyc_o (wait_cyc)
    );

    lcdw_seq #(
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC),
        .EHI_CYC   (EHI_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rs_i       (rs_i),
        .data_i     (data_i),
        .cls_i      (dly_cls_i),
        .wait_cyc_i (wait_cyc),
        .cnt_i      (cnt),
        .hit_i      (hit),
        .cls_o      (cls),
        .term_o     (term),
        .clr_o      (clr),
        .rs_o       (lcd_rs_o),
        .db_o       (lcd_db_o),
        .e_o        (lcd_e_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    // Write-only interface.
    assign lcd_rw_o = 1'b0;

    // Bus values cannot change while a transaction is running.
    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(lcd_db_o) && $stable(lcd_rs_o)));

    // Done coincides with the end of busy.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/lcdw_gen_test.sv
module lcdw_gen_test;

    localparam int S  = 4;
    localparam int H  = 16;
    localparam int W0 = 20;
    localparam int W1 = 35;
    localparam int W2 = 50;
    localparam int W3 = 77;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rs_i = 1'b0;
    logic [7:0] data_i = '0;
    logic [1:0] dly_cls_i = '0;
    logic       lcd_rs_o, lcd_rw_o, lcd_e_o, busy_o, done_o;
    logic [7:0] lcd_db_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lcdw_gen #(
        .SETUP_CYC (S),
        .EHI_CYC   (H),
        .WAIT0_CYC (W0),
        .WAIT1_CYC (W1),
        .WAIT2_CYC (W2),
        .WAIT3_CYC (W3)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rs_i      (rs_i),
        .data_i    (data_i),
        .dly_cls_i (dly_cls_i),
        .lcd_rs_o  (lcd_rs_o),
        .lcd_rw_o  (lcd_rw_o),
        .lcd_e_o   (lcd_e_o),
        .lcd_db_o  (lcd_db_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    function automatic int exp_wait(input logic [1:0] c);
        case (c)
            2'd0:    return W0;
            2'd1:    return W1;
            2'd2:    return W2;
            default: return W3;
        endcase
    endfunction

    function automatic int exp_e(input int t);
        return (t >= S && t < S + H) ? 1 : 0;
    endfunction

    function automatic int exp_busy(input int t, input int total);
        return (t < total) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Runs one transaction from a negedge; ends at the negedge of the done cycle.
    task automatic run_txn(input logic rs, input logic [7:0] d, input logic [1:0] c, input int ign_t);
        int total;
        total = S + H + exp_wait(c);
        start_i = 1'b1; rs_i = rs; data_i = d; dly_cls_i = c;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; rs_i = ~rs; data_i = ~d; dly_cls_i = ~c;
        for (int t = 0; t <= total; t++) begin
            if (t > 0) begin
                @(posedge clk); @(negedge clk);
            end
            if (t == ign_t + 1) start_i = 1'b0;
            check("R4/R5", "lcd_e", int'(lcd_e_o), exp_e(t));
            check("R8", "busy", int'(busy_o), exp_busy(t, total));
            check("R6/R7", "done", int'(done_o), (t == total) ? 1 : 0);
            check("R2", "rw", int'(lcd_rw_o), 0);
            check("R3/R9", "db", int'(lcd_db_o), int'(d));
            check("R3/R9", "rs", int'(lcd_rs_o), int'(rs));
            if (t == ign_t) begin
                // R9: a competing request while busy
                start_i = 1'b1; rs_i = ~rs; data_i = d ^ 8'h5A; dly_cls_i = c + 2'd1;
            end
        end
        start_i = 1'b0;
    endtask

    // Idle gap after a transaction; bus must hold the last write.
    task automatic idle_gap(input int n, input logic rs, input logic [7:0] d);
        for (int g = 0; g < n; g++) begin
            data_i = $urandom; rs_i = $urandom;
            @(posedge clk); @(negedge clk);
            check("R3", "idle db", int'(lcd_db_o), int'(d));
            check("R3", "idle rs", int'(lcd_rs_o), int'(rs));
            check("R8", "idle busy", int'(busy_o), 0);
            check("R7", "idle done", int'(done_o), 0);
        end
    endtask

    initial begin
        logic [7:0] d;
        logic       r;
        logic [1:0] c;
        int         ign;
        void'($urandom(32'd20240611));
        start_i = 1'b1; data_i = 8'hA5; rs_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; start_i = 1'b0;
        // R1: reset state
        check("R1", "reset e", int'(lcd_e_o), 0);
        check("R1", "reset done", int'(done_o), 0);
        check("R1", "reset busy", int'(busy_o), 0);
        check("R1", "reset db", int'(lcd_db_o), 0);
        check("R1", "reset rs", int'(lcd_rs_o), 0);
        check("R2", "reset rw", int'(lcd_rw_o), 0);
        idle_gap(3, 1'b0, 8'h00);

        // Directed: every class, extreme data values
        run_txn(1'b0, 8'h00, 2'd0, -5);
        idle_gap(2, 1'b0, 8'h00);
        run_txn(1'b1, 8'hFF, 2'd1, -5);
        idle_gap(1, 1'b1, 8'hFF);
        run_txn(1'b0, 8'h38, 2'd2, -5);
        idle_gap(1, 1'b0, 8'h38);
        run_txn(1'b1, 8'h48, 2'd3, -5);
        // R10: back-to-back, no gap
        run_txn(1'b0, 8'h01, 2'd2, -5);
        run_txn(1'b1, 8'h65, 2'd0, -5);
        // R9: competing request right after accept and during enable high
        run_txn(1'b0, 8'h0F, 2'd1, 0);
        idle_gap(1, 1'b0, 8'h0F);
        run_txn(1'b1, 8'h6C, 2'd3, S + 2);
        idle_gap(2, 1'b1, 8'h6C);

        // Random transactions with random gaps and competing requests
        for (int k = 0; k < 40; k++) begin
            d = $urandom; r = $urandom; c = $urandom;
            ign = ($urandom_range(0, 1) == 1) ?
                  int'($urandom_range(0, S + H + exp_wait(c) - 2)) : -5;
            run_txn(r, d, c, ign);
            idle_gap($urandom_range(0, 3), r, d);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule